// File: doc/BRIEF.md
# Sigma-Delta Offset and Gain Calibration Sequencer

This controller sits on the host side of a one-bit sigma-delta modulator and runs one calibration measurement each time it is started. It first holds the modulator in reset. It then waits for the modulator's data-valid flag to come back. Next it drives either the zero-input control (offset calibration) or the gain-calibration control and lets the modulator settle. Finally it counts the ones in a power-of-two window of bitstream samples. The measured ones count is compared with the ideal count for the chosen calibration and input mode. The result is a signed density error that downstream logic can use for correction.

The bitstream is a free-running valid-qualified stream. It carries no ready signal, because a modulator cannot be stalled: the sequencer takes every sample that is offered. A sample that goes missing during the measurement window is therefore not back-pressure. It means the modulator has lost validity, and the sequencer aborts with a fault. Start, mode and type inputs and all results are plain level or pulse signals.

A result is tied to the input mode used to produce it. Changing the mode input after completion withdraws the result until the next calibration is run.

Top module: `cal_sequencer`

## Requirements
- R1: After reset, mod_rst, mod_zero, mod_gcal, done, fault and res_ok are all low.
- R2: start is accepted only while idle or done. A start pulse during a running calibration is ignored: the sequence is not restarted, and the type and mode latched at the accepted start are kept.
- R3: An accepted start drives mod_rst high for exactly RST_CYC consecutive cycles, before any calibration control is raised.
- R4: After mod_rst falls, no calibration control rises until at least VALID_WAIT cycles have elapsed and bs_valid is high.
- R5: Exactly one control is raised per run: mod_zero when cal_gain=0 (offset) or mod_gcal when cal_gain=1 (gain). It stays high for SETTLE_CYC settling cycles plus 2^WIN_LOG2 measurement cycles. The two controls are never high together, and never while mod_rst is high.
- R6: ones_cnt equals the number of 1 samples of bs_data over the 2^WIN_LOG2 consecutive samples that follow the settling period.
- R7: The ideal count is as follows. For offset with bip_mode=1 (bipolar) it is 1/2 of the window. For offset with bip_mode=0 (unipolar) it is 3/8 of the window. For gain in either mode it is 5/8 of the window. dens_err is ones_cnt minus the ideal count, in two's complement of width WIN_LOG2+2.
- R8: If bs_valid is low on any measurement cycle, the run ends on the next cycle with done=1, fault=1 and res_ok=0.
- R9: done stays high until the next accepted start. res_ok is high only while done is high, fault is low, and bip_mode has not differed from the mode latched at start since completion. Once a mode difference is seen while done is high, res_ok stays low until the next start, even if the mode is restored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a calibration |
| bip_mode | input | 1 | Input range mode: 1 bipolar, 0 unipolar |
| cal_gain | input | 1 | Calibration type: 1 gain, 0 offset |
| bs_valid | input | 1 | Modulator data-valid flag |
| bs_data | input | 1 | Modulator one-bit stream sample |
| mod_rst | output | 1 | Reset request to the modulator |
| mod_zero | output | 1 | Zero-input control to the modulator |
| mod_gcal | output | 1 | Gain-calibration control to the modulator |
| done | output | 1 | Calibration finished (result or fault) |
| fault | output | 1 | Measurement aborted on loss of data-valid |
| res_ok | output | 1 | Result valid for the current mode |
| ones_cnt | output | WIN_LOG2+1 | Measured ones count |
| dens_err | output | WIN_LOG2+2 | Signed count minus ideal count |

## Verification
The bench builds the block with RST_CYC=3, VALID_WAIT=20, SETTLE_CYC=40 and WIN_LOG2=5. This keeps each run to about a hundred cycles, so every ideal value, both error signs, all-ones and all-zero windows, a mid-window abort and a restart from done all fit in one short run. A 32-sample window is a multiple of the bench's 8-cycle bit pattern, so the expected count does not depend on when measurement starts. The modulator model holds data-valid low for 20 cycles after its reset, which makes the wait for valid recovery visible on the pins.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RST    = 3'd1,
    ST_VWAIT  = 3'd2,
    ST_SETTLE = 3'd3,
    ST_MEAS   = 3'd4,
    ST_DONE   = 3'd5
  } cal_state_t;
endpackage

// File: rtl/cal_tick_timer.sv
module cal_tick_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  output logic [TW-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + TW'(1);
  end

  // R3: a clear always restarts the phase timer from zero
  p_tmr_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/cal_ones_acc.sv
module cal_ones_acc #(
  parameter int WIN_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              din,
  output logic [WIN_LOG2:0] cnt
);
  localparam int CW  = WIN_LOG2 + 1;
  localparam int WIN = 1 << WIN_LOG2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + CW'(din);
  end

  // R6: the ones count never exceeds the window length
  p_acc_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(WIN));
endmodule

// File: rtl/cal_ideal.sv
module cal_ideal #(
  parameter int WIN_LOG2 = 10
) (
  input  logic                       bip,
  input  logic                       gain,
  input  logic [WIN_LOG2:0]          cnt,
  output logic signed [WIN_LOG2+1:0] err
);
  localparam int CW       = WIN_LOG2 + 1;
  localparam int WIN      = 1 << WIN_LOG2;
  localparam int EIGHTH   = WIN / 8;
  localparam logic [CW-1:0] IDL_HALF = CW'(4 * EIGHTH);
  localparam logic [CW-1:0] IDL_UNI  = CW'(3 * EIGHTH);
  localparam logic [CW-1:0] IDL_GAIN = CW'(5 * EIGHTH);

  logic [CW-1:0] ideal;

  always_comb begin
    if (gain)     ideal = IDL_GAIN;
    else if (bip) ideal = IDL_HALF;
    else          ideal = IDL_UNI;
    err = $signed({1'b0, cnt}) - $signed({1'b0, ideal});
  end
endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer #(
  parameter int RST_CYC    = 4,
  parameter int VALID_WAIT = 20,
  parameter int SETTLE_CYC = 1000,
  parameter int WIN_LOG2   = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       bip_mode,
  input  logic                       cal_gain,
  input  logic                       bs_valid,
  input  logic                       bs_data,
  output logic                       mod_rst,
  output logic                       mod_zero,
  output logic                       mod_gcal,
  output logic                       done,
  output logic                       fault,
  output logic                       res_ok,
  output logic [WIN_LOG2:0]          ones_cnt,
  output logic signed [WIN_LOG2+1:0] dens_err
);
  import cal_pkg::*;

  localparam int WIN  = 1 << WIN_LOG2;
  localparam int M1   = (RST_CYC > VALID_WAIT) ? RST_CYC : VALID_WAIT;
  localparam int M2   = (M1 > SETTLE_CYC) ? M1 : SETTLE_CYC;
  localparam int MAXT = (M2 > WIN) ? M2 : WIN;
  localparam int TW   = $clog2(MAXT + 1);
  localparam logic [TW-1:0] T_RST  = TW'(RST_CYC - 1);
  localparam logic [TW-1:0] T_VW   = TW'(VALID_WAIT);
  localparam logic [TW-1:0] T_SET  = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] T_MEAS = TW'(WIN - 1);

  cal_state_t    st, nxt;
  logic [TW-1:0] tmr;
  logic          start_ok, tmr_en, bip_l, gain_l, stale, ctrl_on;

  assign start_ok = start && (st == ST_IDLE || st == ST_DONE);

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE, ST_DONE: if (start_ok) nxt = ST_RST;
      ST_RST:    if (tmr == T_RST) nxt = ST_VWAIT;
      ST_VWAIT:  if (tmr >= T_VW && bs_valid) nxt = ST_SETTLE;
      ST_SETTLE: if (tmr == T_SET) nxt = ST_MEAS;
      ST_MEAS: begin
        if (!bs_valid)          nxt = ST_DONE;
        else if (tmr == T_MEAS) nxt = ST_DONE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st)
      ST_RST, ST_SETTLE, ST_MEAS: tmr_en = 1'b1;
      ST_VWAIT:                   tmr_en = (tmr < T_VW);
      default:                    tmr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      bip_l  <= 1'b0;
      gain_l <= 1'b0;
      fault  <= 1'b0;
      stale  <= 1'b0;
    end else begin
      st <= nxt;
      if (start_ok) begin
        bip_l  <= bip_mode;
        gain_l <= cal_gain;
        fault  <= 1'b0;
        stale  <= 1'b0;
      end else begin
        if (st == ST_MEAS && !bs_valid)        fault <= 1'b1;
        if (st == ST_DONE && bip_mode != bip_l) stale <= 1'b1;
      end
    end
  end

  cal_tick_timer #(.TW(TW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (nxt != st),
    .en    (tmr_en),
    .cnt   (tmr)
  );

  cal_ones_acc #(.WIN_LOG2(WIN_LOG2)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_ok),
    .en    (st == ST_MEAS && bs_valid),
    .din   (bs_data),
    .cnt   (ones_cnt)
  );

  cal_ideal #(.WIN_LOG2(WIN_LOG2)) u_ideal (
    .bip  (bip_l),
    .gain (gain_l),
    .cnt  (ones_cnt),
    .err  (dens_err)
  );

  assign ctrl_on  = (st == ST_SETTLE) || (st == ST_MEAS);
  assign mod_rst  = (st == ST_RST);
  assign mod_zero = ctrl_on && !gain_l;
  assign mod_gcal = ctrl_on && gain_l;
  assign done     = (st == ST_DONE);
  assign res_ok   = done && !fault && !stale && (bip_mode == bip_l);

  // R5: controls are mutually exclusive and never overlap modulator reset
  p_ctrl_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mod_zero && mod_gcal) && !(mod_rst && (mod_zero || mod_gcal)));

  // R2: while a run is in flight the latched type and mode do not move
  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && st != ST_DONE) |=> ($stable(gain_l) && $stable(bip_l)));

  // R4: a control only rises on a cycle after bs_valid was seen high
  p_valid_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_VWAIT && !bs_valid) |=> !(mod_zero || mod_gcal));

  // R8: a missing sample in the window ends the run with a fault
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MEAS && !bs_valid) |=> (done && fault && !res_ok));

  // R9: a mode mismatch seen while done withdraws the result
  p_stale_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start && bip_mode != bip_l) |=> !res_ok);
endmodule

// File: tb/tb_cal_sequencer.sv
module tb_cal_sequencer;
  localparam int RST_CYC    = 3;
  localparam int VALID_WAIT = 20;
  localparam int SETTLE_CYC = 40;
  localparam int WIN_LOG2   = 5;
  localparam int WIN        = 1 << WIN_LOG2;
  localparam int MOD_REC    = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, bip_mode = 1'b0, cal_gain = 1'b0;
  logic bs_valid = 1'b0, bs_data = 1'b0;
  logic mod_rst, mod_zero, mod_gcal, done, fault, res_ok;
  logic [WIN_LOG2:0] ones_cnt;
  logic signed [WIN_LOG2+1:0] dens_err;

  always #2.5 clk = ~clk;

  cal_sequencer #(.RST_CYC(RST_CYC), .VALID_WAIT(VALID_WAIT),
                  .SETTLE_CYC(SETTLE_CYC), .WIN_LOG2(WIN_LOG2)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bip_mode(bip_mode),
    .cal_gain(cal_gain), .bs_valid(bs_valid), .bs_data(bs_data),
    .mod_rst(mod_rst), .mod_zero(mod_zero), .mod_gcal(mod_gcal),
    .done(done), .fault(fault), .res_ok(res_ok),
    .ones_cnt(ones_cnt), .dens_err(dens_err));

  typedef struct {
    int cnt; int err; bit flt; bit gain; int ctrl_cyc;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_bad = 0;
  int cyc = 0, rec = 0;
  int rst_cyc_seen = 0, ctrl_cyc_seen = 0, gap = 0;
  bit saw_zero = 0, saw_gcal = 0, saw_both = 0;
  bit prev_rst = 0, prev_ctrl = 0, prev_done = 0;
  logic [7:0] pat = 8'h0;
  bit kill_en = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // modulator model and monitor
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
    if (rst_n) begin
      if (mod_rst && !prev_rst) begin
        rst_cyc_seen = 0; ctrl_cyc_seen = 0;
        saw_zero = 0; saw_gcal = 0; saw_both = 0;
      end
      if (mod_rst) rst_cyc_seen++;
      if (!mod_rst && !(mod_zero || mod_gcal)) gap++;
      if (mod_rst) gap = 0;
      if (mod_zero) saw_zero = 1;
      if (mod_gcal) saw_gcal = 1;
      if ((mod_zero && mod_gcal) || (mod_rst && (mod_zero || mod_gcal))) saw_both = 1;
      if ((mod_zero || mod_gcal) && !prev_ctrl)
        chk(gap >= VALID_WAIT, "R4 control before valid recovery wait", gap, VALID_WAIT);
      if (mod_zero || mod_gcal) ctrl_cyc_seen++;
      if (done && !prev_done) begin
        exp_t e;
        if (q.size() == 0) begin
          chk(0, "R2 unexpected completion", 1, 0);
        end else begin
          e = q.pop_front();
          chk(rst_cyc_seen == RST_CYC, "R3 reset pulse length", rst_cyc_seen, RST_CYC);
          chk(ctrl_cyc_seen == e.ctrl_cyc, "R5 control high cycles", ctrl_cyc_seen, e.ctrl_cyc);
          chk(saw_gcal == e.gain && saw_zero == !e.gain, "R5 control selection",
              int'({saw_gcal, saw_zero}), int'({e.gain, !e.gain}));
          chk(!saw_both, "R5 control overlap", int'(saw_both), 0);
          chk(fault == e.flt, "R8 fault flag", int'(fault), int'(e.flt));
          chk(res_ok == !e.flt, "R9 result valid at completion", int'(res_ok), int'(!e.flt));
          if (!e.flt) begin
            chk(int'(ones_cnt) == e.cnt, "R6 ones count", int'(ones_cnt), e.cnt);
            chk(int'(dens_err) == e.err, "R7 density error", int'(dens_err), e.err);
          end
        end
      end
      prev_rst  = mod_rst;
      prev_ctrl = mod_zero || mod_gcal;
      prev_done = done;
      // modulator: valid low in reset and for MOD_REC cycles after
      if (mod_rst) begin
        rec = MOD_REC; bs_valid = 1'b0;
      end else if (rec > 0) begin
        rec--; bs_valid = 1'b0;
      end else begin
        bs_valid = !(kill_en && ctrl_cyc_seen == SETTLE_CYC + 5);
      end
      bs_data = pat[cyc % 8];
    end
  end

  task automatic run_cal(input bit bip, input bit gain, input logic [7:0] p,
                         input bit kill, input bit extra_start);
    exp_t e;
    int ideal;
    ideal = gain ? 5 * WIN / 8 : (bip ? WIN / 2 : 3 * WIN / 8);
    e.cnt = $countones(p) * (WIN / 8);
    e.err = e.cnt - ideal;
    e.flt = kill;
    e.gain = gain;
    e.ctrl_cyc = kill ? SETTLE_CYC + 5 : SETTLE_CYC + WIN;
    q.push_back(e);
    pat = p; kill_en = kill;
    bip_mode = bip; cal_gain = gain; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    if (extra_start) begin
      while (!(mod_zero || mod_gcal)) @(negedge clk);
      repeat (10) @(negedge clk);
      // R2: this start must be ignored
      cal_gain = !gain; bip_mode = !bip; start = 1'b1;
      @(negedge clk);
      start = 1'b0; bip_mode = bip; cal_gain = gain;
    end
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
    kill_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!mod_rst && !mod_zero && !mod_gcal, "R1 controls in reset",
        int'({mod_rst, mod_zero, mod_gcal}), 0);
    chk(!done && !fault && !res_ok, "R1 status in reset", int'({done, fault, res_ok}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mod_rst && !done && !res_ok, "R1 idle after reset", int'({mod_rst, done, res_ok}), 0);

    run_cal(1, 0, 8'b0101_0101, 0, 0);  // R7 offset bipolar, exact
    run_cal(0, 0, 8'b0001_0011, 0, 0);  // R7 offset unipolar, exact
    run_cal(0, 0, 8'b0111_0011, 0, 0);  // R7 unipolar positive error
    run_cal(0, 1, 8'b1011_0101, 0, 0);  // R7 gain unipolar, exact
    run_cal(1, 1, 8'b1000_0001, 0, 0);  // R7 gain bipolar negative error
    run_cal(1, 0, 8'hFF, 0, 0);         // R6 all ones
    run_cal(0, 1, 8'h00, 0, 0);         // R6 all zeros
    run_cal(1, 0, 8'b0110_0110, 1, 0);  // R8 abort mid-window
    run_cal(1, 1, 8'b1101_0110, 0, 1);  // R2 start ignored while busy

    // R9: a mode change after completion withdraws the result, stickily
    chk(done && res_ok, "R9 result valid before mode change", int'({done, res_ok}), 3);
    bip_mode = 1'b0;
    repeat (2) @(negedge clk);
    chk(done && !res_ok, "R9 result withdrawn on mode change", int'({done, res_ok}), 2);
    bip_mode = 1'b1;
    repeat (2) @(negedge clk);
    chk(done && !res_ok, "R9 withdrawal sticky after restore", int'({done, res_ok}), 2);

    run_cal(1, 0, 8'b0011_1100, 0, 0);  // R2 restart from done
    chk(res_ok, "R9 fresh start revalidates", int'(res_ok), 1);
    chk(q.size() == 0, "R2 all runs completed", q.size(), 0);
    finish_run();
  end
endmodule